// File: doc/BRIEF.md
# Pad Boundary Register Chain

This block is the boundary register of a JTAG (IEEE 1149.1) test port. It sits between the core logic and twelve pads. For each pad it holds a capture/shift stage and an update latch, so the tester can observe what the pads and the core present and, under the right instruction, take over the pad drivers. A separate TAP controller supplies the Capture-DR, Shift-DR and Update-DR strobes. The same controller supplies one decoded flag per supported instruction. The block returns serial data on `tdo`.

The chain is 24 cells long. Cell 0 is the cell nearest `tdo`. Each bidirectional pad owns two cells: a data cell at cell 2p and, directly above it, an output-enable control cell at cell 2p+1. Pad 3 is input-only. Its slot holds an observe cell at cell 6, which has no update stage. The cell above it, cell 7, is an extra output-only cell. It drives a second, always-enabled output (`pad_aux`) on pad 4. When neither the sample/preload nor the external-test flag is raised, a one-bit bypass register takes the place of the chain between `tdi` and `tdo`.

Top module: `bscan_chain`

## Requirements
- R1: After `rst_n` is low, all 24 update latches, the shift stages and the bypass bit are 0. With no instruction flag raised, `tdo` reads 0.
- R2: While `sel_sample` or `sel_extest` is high, each clock with `shift_dr` high moves the chain one cell toward `tdo`. `tdi` enters cell 23, and `tdo` shows cell 0, so a bit reaches `tdo` 24 shifts after it entered.
- R3: On a `capture_dr` clock with the chain selected, each cell loads a fixed source. Even cells 0, 2, 4 and 8 to 22 load `pad_in[cell/2]`. Cell 6 loads `pad_in[3]`. Odd cells other than 7 load `core_oe[(cell-1)/2]`. Cell 7 loads `core_aux`.
- R4: The update latches change only on an `update_dr` clock with the chain selected, when they copy the shift stages. Pad outputs under EXTEST stay constant while the chain shifts.
- R5: With `sel_extest` or `sel_clamp` high, every pad p other than 3 takes `pad_oe[p]` from the latch of cell 2p+1 and `pad_out[p]` from the latch of cell 2p. A latch value of 1 enables the driver. `pad_aux` takes the latch of cell 7.
- R6: With neither `sel_extest` nor `sel_clamp` high, `pad_out`, `pad_oe` and `pad_aux` pass `core_out`, `core_oe` and `core_aux` through unchanged. `core_in` always equals `pad_in`.
- R7: With `sel_highz` high, all twelve `pad_oe` bits are 0. `pad_out` and `pad_aux` still pass the core values.
- R8: Pad 3 never drives from the chain. Under EXTEST, CLAMP or HIGHZ its `pad_oe[3]` is 0. Its `pad_out[3]` always equals `core_out[3]`.
- R9: At most one instruction flag is high at a time. Under CLAMP, HIGHZ or no flag, the bypass bit sits between `tdi` and `tdo`: capture loads it with 0 and shift loads it from `tdi`. The chain's shift stages and latches are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low test-logic reset |
| capture_dr | input | 1 | Capture strobe from the TAP controller |
| shift_dr | input | 1 | Shift strobe from the TAP controller |
| update_dr | input | 1 | Update strobe from the TAP controller |
| tdi | input | 1 | Serial test data in |
| sel_sample | input | 1 | Sample/preload instruction active |
| sel_extest | input | 1 | External-test instruction active |
| sel_clamp | input | 1 | Clamp instruction active |
| sel_highz | input | 1 | High-impedance instruction active |
| core_out | input | 12 | Core output value per pad |
| core_oe | input | 12 | Core output enable per pad (1 = drive) |
| core_aux | input | 1 | Core value for the second output on pad 4 |
| core_in | output | 12 | Pad input values returned to the core |
| pad_out | output | 12 | Output value to each pad |
| pad_oe | output | 12 | Output enable to each pad (1 = drive) |
| pad_aux | output | 1 | Second, always-enabled output on pad 4 |
| pad_in | input | 12 | Input value received from each pad |
| tdo | output | 1 | Serial test data out |

## Verification
Several rules are checked on every clock. The shift stages move by exactly one place per Shift-DR clock. The latches hold across any clock without a selected Update-DR. HIGHZ keeps every output enable low, and pad 3 never drives under a test instruction. Capture of the bypass bit to 0 and the rule that at most one instruction flag is high are also checked each clock. The mapping of each cell to its pad, the capture sources and the shift order toward `tdo` can only be shown by the bench. It captures and shifts out many pad and core patterns and compares each bit against the documented cell numbering. The bench also preloads latch patterns and reads them back at the pads under EXTEST and CLAMP.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
    localparam int NUM_PADS  = 12;
    localparam int CHAIN_LEN = 2 * NUM_PADS;
    localparam int OBS_CELL  = 6;
    localparam int AUX_CELL  = 7;
    localparam int OBS_PAD   = OBS_CELL / 2;
    localparam int AUX_PAD   = (AUX_CELL + 1) / 2;

    typedef enum logic [1:0] {
        CELL_BIDIR,
        CELL_CTRL,
        CELL_OBS,
        CELL_AUX
    } cell_kind_e;

    typedef struct packed {
        logic [CHAIN_LEN-1:0] sr;
        logic [CHAIN_LEN-1:0] upd;
    } cell_state_t;

    function automatic cell_kind_e kind_of(input int idx);
        if (idx == OBS_CELL) return CELL_OBS;
        if (idx == AUX_CELL) return CELL_AUX;
        if ((idx % 2) == 1)  return CELL_CTRL;
        return CELL_BIDIR;
    endfunction

    function automatic int pad_of(input int idx);
        if (idx == AUX_CELL) return AUX_PAD;
        return idx / 2;
    endfunction
endpackage

// File: rtl/bsc_cells.sv
module bsc_cells
    import bsc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 capture_dr,
    input  logic                 shift_dr,
    input  logic                 update_dr,
    input  logic                 tdi,
    input  logic [CHAIN_LEN-1:0] cap_vec,
    output logic [CHAIN_LEN-1:0] latch,
    output logic                 serial_out
);
    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel) begin
            if (capture_dr) begin
                st_d.sr = cap_vec;
            end else if (shift_dr) begin
                st_d.sr = {tdi, st_q.sr[CHAIN_LEN-1:1]};
            end
            if (update_dr) begin
                st_d.upd           = st_q.sr;
                st_d.upd[OBS_CELL] = 1'b0;   // observe cell: no update stage
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch      = st_q.upd;
    assign serial_out = st_q.sr[0];

    // R2
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && shift_dr && !capture_dr) |=> st_q.sr[CHAIN_LEN-2:0] == $past(st_q.sr[CHAIN_LEN-1:1]));

    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && update_dr) |=> $stable(st_q.upd));
endmodule

// File: rtl/bsc_bypass.sv
module bsc_bypass (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic tdi,
    output logic bit_out
);
    logic byp_d, byp_q;

    always_comb begin
        byp_d = byp_q;
        if (sel) begin
            if (capture_dr)    byp_d = 1'b0;
            else if (shift_dr) byp_d = tdi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) byp_q <= 1'b0;
        else        byp_q <= byp_d;
    end

    assign bit_out = byp_q;

    // R9
    byp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && capture_dr) |=> !bit_out);
endmodule

// File: rtl/bsc_pad_mux.sv
module bsc_pad_mux
    import bsc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 drive,
    input  logic                 sel_highz,
    input  logic [CHAIN_LEN-1:0] latch,
    input  logic [NUM_PADS-1:0]  core_out,
    input  logic [NUM_PADS-1:0]  core_oe,
    input  logic                 core_aux,
    output logic [NUM_PADS-1:0]  pad_out,
    output logic [NUM_PADS-1:0]  pad_oe,
    output logic                 pad_aux
);
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        localparam int DC = 2 * p;
        if (p == OBS_PAD) begin : g_obs
            logic unused_obs_latch;
            assign unused_obs_latch = latch[DC];
            assign pad_out[p] = core_out[p];
            assign pad_oe[p]  = (drive || sel_highz) ? 1'b0 : core_oe[p];
        end else begin : g_bidir
            assign pad_out[p] = drive ? latch[DC] : core_out[p];
            assign pad_oe[p]  = sel_highz ? 1'b0 : (drive ? latch[DC+1] : core_oe[p]);
        end
    end

    assign pad_aux = drive ? latch[AUX_CELL] : core_aux;

    // R7
    highz_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_highz |-> (pad_oe == '0));

    // R8
    obs_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> (!pad_oe[OBS_PAD] && pad_out[OBS_PAD] == core_out[OBS_PAD]));
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bsc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture_dr,
    input  logic                shift_dr,
    input  logic                update_dr,
    input  logic                tdi,
    input  logic                sel_sample,
    input  logic                sel_extest,
    input  logic                sel_clamp,
    input  logic                sel_highz,
    input  logic [NUM_PADS-1:0] core_out,
    input  logic [NUM_PADS-1:0] core_oe,
    input  logic                core_aux,
    output logic [NUM_PADS-1:0] core_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic                pad_aux,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic                tdo
);
    logic                 chain_sel;
    logic                 drive;
    logic [CHAIN_LEN-1:0] cap_vec;
    logic [CHAIN_LEN-1:0] latch;
    logic                 chain_so;
    logic                 byp_so;

    assign chain_sel = sel_sample || sel_extest;
    assign drive     = sel_extest || sel_clamp;

    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cap
        localparam cell_kind_e K = kind_of(i);
        localparam int         P = pad_of(i);
        if (K == CELL_CTRL) begin : g_ctrl
            assign cap_vec[i] = core_oe[P];
        end else if (K == CELL_AUX) begin : g_aux
            assign cap_vec[i] = core_aux;
        end else begin : g_in
            assign cap_vec[i] = pad_in[P];
        end
    end

    bsc_cells u_cells (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (chain_sel),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .cap_vec    (cap_vec),
        .latch      (latch),
        .serial_out (chain_so)
    );

    bsc_bypass u_bypass (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (!chain_sel),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .tdi        (tdi),
        .bit_out    (byp_so)
    );

    bsc_pad_mux u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .drive     (drive),
        .sel_highz (sel_highz),
        .latch     (latch),
        .core_out  (core_out),
        .core_oe   (core_oe),
        .core_aux  (core_aux),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_aux   (pad_aux)
    );

    assign core_in = pad_in;
    assign tdo     = chain_sel ? chain_so : byp_so;

    // R9
    instr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_sample, sel_extest, sel_clamp, sel_highz}));

    // R6
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive && !sel_highz) |-> (pad_out == core_out && pad_oe == core_oe && pad_aux == core_aux));
endmodule

// File: tb/test_bscan_chain.sv
module test_bscan_chain;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 12;
    localparam int NC = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cap = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
    logic s_sp = 1'b0, s_ex = 1'b0, s_cl = 1'b0, s_hz = 1'b0;
    logic [NP-1:0] core_out = '0, core_oe = '0, pad_in = '0;
    logic [NP-1:0] core_in, pad_out, pad_oe;
    logic core_aux = 1'b0, pad_aux, tdo;
    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bscan_chain i_bscan_chain (
        .clk(clk), .rst_n(rst_n), .capture_dr(cap), .shift_dr(sh), .update_dr(upd),
        .tdi(tdi), .sel_sample(s_sp), .sel_extest(s_ex), .sel_clamp(s_cl), .sel_highz(s_hz),
        .core_out(core_out), .core_oe(core_oe), .core_aux(core_aux), .core_in(core_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_aux(pad_aux), .pad_in(pad_in), .tdo(tdo)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_instr(input int which);
        s_sp = (which == 1); s_ex = (which == 2); s_cl = (which == 3); s_hz = (which == 4);
    endtask

    function automatic logic [NC-1:0] exp_cap(input logic [NP-1:0] pin, input logic [NP-1:0] coe, input logic aux);
        logic [NC-1:0] v;
        for (int i = 0; i < NC; i++) begin
            if (i == 7)           v[i] = aux;
            else if (i == 6)      v[i] = pin[3];
            else if (i % 2 == 1)  v[i] = coe[(i-1)/2];
            else                  v[i] = pin[i/2];
        end
        return v;
    endfunction

    task automatic chk_pads(input logic [NC-1:0] lat, input string req);
        logic drv;
        logic [NP-1:0] eo, ee;
        logic ea;
        drv = s_ex | s_cl;
        for (int p = 0; p < NP; p++) begin
            if (p == 3) begin
                ee[p] = (s_hz | drv) ? 1'b0 : core_oe[p];
                eo[p] = core_out[p];
            end else begin
                ee[p] = s_hz ? 1'b0 : (drv ? lat[2*p+1] : core_oe[p]);
                eo[p] = drv ? lat[2*p] : core_out[p];
            end
        end
        ea = drv ? lat[7] : core_aux;
        chk(pad_out[11:4] == eo[11:4] && pad_out[2:0] == eo[2:0], req, pad_out, eo);
        chk(pad_oe[11:4] == ee[11:4] && pad_oe[2:0] == ee[2:0], req, pad_oe, ee);
        chk(pad_aux == ea, req, pad_aux, ea);
        chk(pad_oe[3] == ee[3] && pad_out[3] == eo[3], "R8 input-only pad", {pad_oe[3], pad_out[3]}, {ee[3], eo[3]});
        chk(core_in == pad_in, "R6 core_in", core_in, pad_in);
    endtask

    task automatic do_capture();
        cap = 1'b1; tick(); cap = 1'b0;
    endtask

    task automatic do_update();
        upd = 1'b1; tick(); upd = 1'b0;
    endtask

    task automatic shift_vec(input logic [NC-1:0] vin, input logic [NC-1:0] vexp, input bit chk_out,
                             input bit hold_pads, input logic [NC-1:0] lat);
        for (int j = 0; j < NC; j++) begin
            if (chk_out) chk(tdo == vexp[j], "R2/R3 shift-out bit", tdo, vexp[j]);
            if (hold_pads) chk_pads(lat, "R4 hold during shift");
            tdi = vin[j]; sh = 1'b1; tick();
        end
        sh = 1'b0;
    endtask

    function automatic logic [NC-1:0] pat(input int k);
        return 24'hA5F00F ^ (24'h13579B * (k + 1)) ^ (24'h800001 << (k % 3));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [NC-1:0] lat, nxt, capv;
        tick(); tick();
        rst_n = 1'b1; tick();
        // R1 reset state
        chk(tdo == 1'b0, "R1 tdo after reset", tdo, 0);
        chk_pads('0, "R6 passthrough after reset");
        set_instr(2); tick();
        chk_pads('0, "R1 latches zero");
        set_instr(0);

        // R6 passthrough sweep
        for (int k = 0; k < 16; k++) begin
            core_out = 12'(k * 12'h1A5 ^ 12'h3C3);
            core_oe  = 12'(~(k * 12'h0B7));
            core_aux = k[0];
            pad_in   = 12'(k * 12'h2D1);
            set_instr((k % 2 == 0) ? 0 : 1);
            tick();
            chk_pads('0, "R6 passthrough sweep");
        end

        // R3/R2/R5 sample, shift, preload, then extest drive
        for (int k = 0; k < 8; k++) begin
            pad_in   = 12'(12'h5A7 ^ (k * 12'h111));
            core_oe  = 12'(12'hC3A + k * 12'h095);
            core_aux = ~k[1];
            core_out = 12'(k * 12'h0F3);
            capv = exp_cap(pad_in, core_oe, core_aux);
            set_instr(1);
            do_capture();
            shift_vec(pat(k), capv, 1'b1, 1'b0, '0);
            do_update();
            chk_pads('0, "R6 sample keeps passthrough");
            set_instr(2); tick();
            lat = pat(k); lat[6] = 1'b0;
            chk_pads(lat, "R5 extest drive");
        end

        // R4 hold during extest shift, then update applies
        nxt = ~pat(3);
        shift_vec(nxt, '0, 1'b0, 1'b1, lat);
        chk_pads(lat, "R4 hold before update");
        do_update();
        lat = nxt; lat[6] = 1'b0;
        chk_pads(lat, "R4 new latch after update");

        // R9 clamp: bypass path, latches untouched, pads held
        set_instr(3); tick();
        chk_pads(lat, "R5 clamp drive");
        do_capture();
        chk(tdo == 1'b0, "R9 bypass capture", tdo, 0);
        tdi = 1'b1; sh = 1'b1; tick();
        chk(tdo == 1'b1, "R9 bypass shift 1", tdo, 1);
        tdi = 1'b0; tick(); sh = 1'b0;
        chk(tdo == 1'b0, "R9 bypass shift 0", tdo, 0);
        do_update();
        chk_pads(lat, "R9 clamp update ignored");
        set_instr(1); tick();
        shift_vec('0, nxt, 1'b1, 1'b0, '0);

        // R7 highz
        core_oe = '1; core_out = 12'hA5C; core_aux = 1'b1;
        set_instr(4); tick();
        chk(pad_oe == '0, "R7 highz oe", pad_oe, 0);
        chk_pads(lat, "R7 highz passthrough values");
        do_capture();
        chk(tdo == 1'b0, "R9 highz bypass", tdo, 0);

        // R1 reset clears latches
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        set_instr(2); tick();
        chk_pads('0, "R1 reset clears latches");
        set_instr(0); tick();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule